// File: doc/BRIEF.md
# Debug Probe Reset, Power and Sense Register

This block is the control and status word of a debug probe. It drives the probe's test-logic reset and system reset lines toward the target. It also drives the target power switch and two indicator LEDs. Software changes these outputs through two write ports that share one data word. A write on the set port turns on every control bit that has a 1 in the mask. A write on the clear port turns off every control bit that has a 1 in the mask. In both cases the unmasked bits keep their value, so no read-modify-write is needed.

Two lines come back from the target: a system-reset sense line and a supply-good line. Each passes through a synchronizer and feeds a sticky flag. A flag stays set after the event has gone. Software re-arms a flag by writing its bit through the set port. The re-arm loads the present synchronized state of the line, not zero. A read after the re-arm therefore tells whether the condition still holds. Software uses this to poll for the target's reset to float back up after the probe releases it. The reset-sense flag is blind while the probe itself drives system reset, so the probe never reports its own reset.

The read word is always visible. It packs the control bits and the two flags into one byte.

Top module: `probe_ctl_reg`

## Requirements
- R1: A set-port write (wr_valid_i=1, wr_clr_i=0) ORs wr_mask_i into the control bits 0, 1, 3, 4 and 5. The other control bits do not change. The result is visible after the next rising clock edge.
- R2: A clear-port write (wr_valid_i=1, wr_clr_i=1) clears the control bits 0, 1, 3, 4 and 5 that have a 1 in wr_mask_i. The other control bits do not change.
- R3: The output pins follow the control bits: bit 0 drives jtag_trst_o, bit 1 drives sys_srst_o, bit 3 drives tgt_pwr_en_o, and bits 4 and 5 drive led_o[0] and led_o[1]. Bit 2 of rd_data_o always reads 0, and writes to bit 2 have no effect.
- R4: While rst_n is low at a clock edge, all control bits and both flags go to 0. Target power is therefore off until software writes it.
- R5: rd_data_o carries the control bits in positions 0 to 5, the reset-sense flag in bit 6 and the supply-dropout flag in bit 7.
- R6: When tgt_srst_asserted_i goes to 1, flag bit 6 becomes 1 after the third rising edge: two synchronizer stages, then the flag register. The flag stays 1 after the line drops, until it is re-armed.
- R7: A set-port write with mask bit 6 (for the reset-sense flag) or mask bit 7 (for the dropout flag) re-arms that flag. It loads the current synchronized condition, so the flag reads 1 if the condition is still present and 0 otherwise. Re-arm takes priority over a new event in the same cycle.
- R8: When tgt_supply_ok_i is 0 for a single sampled cycle, flag bit 7 becomes 1 after the third rising edge and stays set.
- R9: While control bit 1 (system reset drive) is 1, the sense line cannot set flag bit 6. Once the drive is released, a sense line that is still active sets the flag one edge later.
- R10: A clear-port write does not change either flag, whatever its mask bits 6 and 7 hold.
- R11: With no write, the control bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe for one cycle |
| wr_clr_i | input | 1 | Selects the port: 0 = set, 1 = clear |
| wr_mask_i | input | 8 | Bit mask of the write |
| tgt_srst_asserted_i | input | 1 | Target system reset seen active (asynchronous) |
| tgt_supply_ok_i | input | 1 | Target supply present (asynchronous) |
| jtag_trst_o | output | 1 | Test-logic reset drive |
| sys_srst_o | output | 1 | System reset drive |
| tgt_pwr_en_o | output | 1 | Target power switch enable |
| led_o | output | 2 | Indicator LEDs |
| rd_data_o | output | 8 | Control bits and sticky flags |

## Verification
The assertions assume that a write lasts exactly one cycle per strobe and selects one port at a time. They also assume the sense inputs are only judged through the synchronized path, never at the edge where they change.

The bench drives every input at the falling edge, so each write is seen by exactly one rising edge. The sense lines are held or pulsed for whole cycles. The flag latency is then an exact count of edges, and the control bits follow a model that the bench computes from the masks alone.

// File: rtl/probe_ctl_pkg.sv
// Package: bit positions of the probe control/status word and the control
// state type. Assumes an 8-bit word; positions are fixed by software use.
package probe_ctl_pkg;

    localparam int REG_W         = 8;
    localparam int BIT_TRST      = 0;
    localparam int BIT_SRST      = 1;
    localparam int BIT_SPARE     = 2;
    localparam int BIT_PWR       = 3;
    localparam int BIT_LED0      = 4;
    localparam int BIT_LED1      = 5;
    localparam int BIT_SRST_SEEN = 6;
    localparam int BIT_DROP_SEEN = 7;
    localparam int NUM_SENSE     = 2;
    localparam int SENSE_SRST    = 0;
    localparam int SENSE_SUPPLY  = 1;

    localparam logic [REG_W-1:0] CTRL_MASK = 8'h3B;

    typedef struct packed {
        logic led1;
        logic led0;
        logic pwr;
        logic srst;
        logic trst;
    } ctrl_t;

    // Pick the control fields out of a full-width word.
    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.trst = w[BIT_TRST];
        c.srst = w[BIT_SRST];
        c.pwr  = w[BIT_PWR];
        c.led0 = w[BIT_LED0];
        c.led1 = w[BIT_LED1];
        return c;
    endfunction

endpackage

// File: rtl/probe_sync_chain.sv
// Multi-stage synchronizer for a bundle of independent asynchronous lines.
// Assumes each line is a level, not a pulse shorter than a clock period.
// RST_VAL gives each line's inactive level so reset raises no false event.
module probe_sync_chain #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw asynchronous lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            // Later stages: pass the value down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/probe_ctl_bits.sv
// Control state with a set port and a clear port. Only the control fields
// are stored; other mask bits are ignored here. Assumes that at most one
// of wr_set_i / wr_clr_i is high in a cycle.
module probe_ctl_bits
    import probe_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_set_i,
    input  logic             wr_clr_i,
    input  logic [REG_W-1:0] mask_i,
    output ctrl_t            ctrl_o
);

    ctrl_t mask_c;
    ctrl_t ctrl_q;

    // Reduce the incoming word to the control fields.
    always_comb mask_c = word_to_ctrl(mask_i);

    // Update the control state: OR on set, AND-NOT on clear, all off at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (wr_set_i) ctrl_q <= ctrl_q | mask_c;
        else if (wr_clr_i) ctrl_q <= ctrl_q & ~mask_c;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/probe_sticky_flag.sv
// Sticky event flag with sample-and-clear re-arm. Assumes event_i is
// already synchronous. A re-arm loads the present event level, so a
// condition that persists is reported again at once.
module probe_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic rearm_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag once set; a re-arm replaces it with the current level.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (rearm_i) flag_q <= event_i;
        else              flag_q <= flag_q | event_i;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/probe_ctl_reg.sv
// Probe reset/power/LED control with sticky target sense flags.
// Assumes one-cycle write strobes and asynchronous, level-type sense
// inputs. The reset-sense event is masked while the probe drives reset.
module probe_ctl_reg
    import probe_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid_i,
    input  logic             wr_clr_i,
    input  logic [REG_W-1:0] wr_mask_i,
    input  logic             tgt_srst_asserted_i,
    input  logic             tgt_supply_ok_i,
    output logic             jtag_trst_o,
    output logic             sys_srst_o,
    output logic             tgt_pwr_en_o,
    output logic [1:0]       led_o,
    output logic [REG_W-1:0] rd_data_o
);

    localparam logic [NUM_SENSE-1:0] SENSE_IDLE = NUM_SENSE'(1) << SENSE_SUPPLY;

    logic                 wr_set;
    logic                 wr_clear;
    ctrl_t                ctrl;
    logic [NUM_SENSE-1:0] sense_raw;
    logic [NUM_SENSE-1:0] sense_sync;
    logic [NUM_SENSE-1:0] sense_event;
    logic [NUM_SENSE-1:0] sense_rearm;
    logic [NUM_SENSE-1:0] sense_flag;
    logic [REG_W-1:0]     rd_word;

    // Decode the strobe into the two write ports.
    always_comb begin
        wr_set   = wr_valid_i & ~wr_clr_i;
        wr_clear = wr_valid_i &  wr_clr_i;
    end

    probe_ctl_bits u_ctl_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_set_i (wr_set),
        .wr_clr_i (wr_clear),
        .mask_i   (wr_mask_i),
        .ctrl_o   (ctrl)
    );

    // Gather the asynchronous sense lines into one bundle.
    always_comb begin
        sense_raw               = '0;
        sense_raw[SENSE_SRST]   = tgt_srst_asserted_i;
        sense_raw[SENSE_SUPPLY] = tgt_supply_ok_i;
    end

    probe_sync_chain #(
        .WIDTH   (NUM_SENSE),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SENSE_IDLE)
    ) u_sense_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sense_raw),
        .sync_o  (sense_sync)
    );

    // Form the event conditions and the re-arm strobes (set port only).
    always_comb begin
        sense_event               = '0;
        sense_event[SENSE_SRST]   = sense_sync[SENSE_SRST] & ~ctrl.srst;
        sense_event[SENSE_SUPPLY] = ~sense_sync[SENSE_SUPPLY];
        sense_rearm               = '0;
        sense_rearm[SENSE_SRST]   = wr_set & wr_mask_i[BIT_SRST_SEEN];
        sense_rearm[SENSE_SUPPLY] = wr_set & wr_mask_i[BIT_DROP_SEEN];
    end

    for (genvar s = 0; s < NUM_SENSE; s++) begin : g_flag
        probe_sticky_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .event_i (sense_event[s]),
            .rearm_i (sense_rearm[s]),
            .flag_o  (sense_flag[s])
        );
    end

    // Pack controls and flags into the read word.
    always_comb begin
        rd_word                = '0;
        rd_word[BIT_TRST]      = ctrl.trst;
        rd_word[BIT_SRST]      = ctrl.srst;
        rd_word[BIT_SPARE]     = 1'b0;
        rd_word[BIT_PWR]       = ctrl.pwr;
        rd_word[BIT_LED0]      = ctrl.led0;
        rd_word[BIT_LED1]      = ctrl.led1;
        rd_word[BIT_SRST_SEEN] = sense_flag[SENSE_SRST];
        rd_word[BIT_DROP_SEEN] = sense_flag[SENSE_SUPPLY];
    end

    assign rd_data_o    = rd_word;
    assign jtag_trst_o  = ctrl.trst;
    assign sys_srst_o   = ctrl.srst;
    assign tgt_pwr_en_o = ctrl.pwr;
    assign led_o        = {ctrl.led1, ctrl.led0};

endmodule

// File: rtl/probe_ctl_chk.sv
// Checker for probe_ctl_reg: relates writes, the read word and the flags
// across clock edges. Observes ports only.
module probe_ctl_chk
    import probe_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid_i,
    input logic             wr_clr_i,
    input logic [REG_W-1:0] wr_mask_i,
    input logic [REG_W-1:0] rd_data_o
);

    AST_SET_ORS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !wr_clr_i) |=> ((rd_data_o & CTRL_MASK) == (($past(rd_data_o) | $past(wr_mask_i)) & CTRL_MASK))); // R1

    AST_CLR_ANDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_clr_i) |=> ((rd_data_o & CTRL_MASK) == ($past(rd_data_o) & ~$past(wr_mask_i) & CTRL_MASK))); // R2

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[BIT_SPARE] == 1'b0); // R3

    AST_SRST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[BIT_SRST_SEEN] && !(wr_valid_i && !wr_clr_i && wr_mask_i[BIT_SRST_SEEN])) |=> rd_data_o[BIT_SRST_SEEN]); // R6

    AST_DROP_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[BIT_DROP_SEEN] && !(wr_valid_i && !wr_clr_i && wr_mask_i[BIT_DROP_SEEN])) |=> rd_data_o[BIT_DROP_SEEN]); // R8

    AST_NO_SELF_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data_o[BIT_SRST_SEEN] && rd_data_o[BIT_SRST] && !(wr_valid_i && !wr_clr_i && wr_mask_i[BIT_SRST_SEEN])) |=> !rd_data_o[BIT_SRST_SEEN]); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> $stable(rd_data_o & CTRL_MASK)); // R11

endmodule

bind probe_ctl_reg probe_ctl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .wr_clr_i   (wr_clr_i),
    .wr_mask_i  (wr_mask_i),
    .rd_data_o  (rd_data_o)
);

// File: tb/probe_ctl_reg_tb_top.sv
// Bench for probe_ctl_reg: mask sweeps on both ports, then flag timing,
// re-arm, self-sense masking and reset. Inputs change on falling edges.
module probe_ctl_reg_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          FLAG_LAT   = 3;
    localparam logic [7:0]  CTRL_BITS  = 8'h3B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_clr = 1'b0;
    logic [7:0] wr_mask = '0;
    logic       srst_sense = 1'b0;
    logic       supply_ok = 1'b1;
    logic       trst_o, srst_o, pwr_o;
    logic [1:0] led;
    logic [7:0] rd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    probe_ctl_reg dut_i (
        .clk                 (clk),
        .rst_n               (rst_n),
        .wr_valid_i          (wr_valid),
        .wr_clr_i            (wr_clr),
        .wr_mask_i           (wr_mask),
        .tgt_srst_asserted_i (srst_sense),
        .tgt_supply_ok_i     (supply_ok),
        .jtag_trst_o         (trst_o),
        .sys_srst_o          (srst_o),
        .tgt_pwr_en_o        (pwr_o),
        .led_o               (led),
        .rd_data_o           (rd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic clr, input logic [7:0] m);
        @(negedge clk);
        wr_valid = 1'b1; wr_clr = clr; wr_mask = m;
        @(negedge clk);
        wr_valid = 1'b0; wr_clr = 1'b0; wr_mask = '0;
    endtask

    function automatic logic [7:0] pins();
        return {2'b00, led, pwr_o, 1'b0, srst_o, trst_o};
    endfunction

    initial begin
        step(3);
        check("R4 reset word", rd, 8'h00);
        check("R4 reset pins", pins(), 8'h00);
        rst_n = 1'b1;
        step(2);
        check("R4 power off after reset", {7'd0, pwr_o}, 8'h00);

        // R1 sweep: every set mask from an all-off state
        for (int m = 0; m < 256; m++) begin
            do_write(1'b1, 8'hFF);
            do_write(1'b0, 8'(m));
            check("R1 set sweep", rd, 8'(m) & CTRL_BITS);
            check("R3 pin map set", pins(), 8'(m) & CTRL_BITS);
        end
        // R2 sweep: every clear mask from an all-on state
        for (int m = 0; m < 256; m++) begin
            do_write(1'b0, CTRL_BITS);
            do_write(1'b1, 8'(m));
            check("R2 clear sweep", rd, CTRL_BITS & ~8'(m));
            check("R3 pin map clear", pins(), CTRL_BITS & ~8'(m));
        end
        // R3 bit 2 write is inert
        do_write(1'b1, 8'hFF);
        do_write(1'b0, 8'h04);
        check("R3 spare bit", rd, 8'h00);
        // R1 accumulate across writes
        do_write(1'b0, 8'h30);
        do_write(1'b0, 8'h08);
        check("R1 accumulate", rd, 8'h38);
        // R11 idle holds
        step(10);
        check("R11 idle hold", rd, 8'h38);
        do_write(1'b1, 8'hFF);

        // R6 latency and stickiness
        @(negedge clk); srst_sense = 1'b1;
        @(negedge clk); srst_sense = 1'b0;
        step(FLAG_LAT - 2);
        check("R6 flag not before third edge", rd, 8'h00);
        step(1);
        check("R6 flag at third edge", rd, 8'h40);
        step(5);
        check("R6 flag sticky", rd, 8'h40);
        do_write(1'b0, 8'h40);
        check("R7 rearm idle line gives 0", rd, 8'h00);
        // R7 rearm with condition present loads 1
        srst_sense = 1'b1;
        step(5);
        do_write(1'b0, 8'h40);
        check("R7 rearm active line gives 1", rd, 8'h40);
        srst_sense = 1'b0;
        step(4);
        do_write(1'b0, 8'h40);
        check("R7 rearm after drop", rd, 8'h00);

        // R9 own reset not sensed
        do_write(1'b0, 8'h02);
        srst_sense = 1'b1;
        step(6);
        check("R9 masked while driving", rd, 8'h02);
        do_write(1'b1, 8'h02);
        check("R9 release edge still masked", rd, 8'h00);
        step(1);
        check("R9 sensed after release", rd, 8'h40);
        srst_sense = 1'b0;
        step(4);
        do_write(1'b0, 8'h40);
        check("R9 rearm after line floats up", rd, 8'h00);

        // R8 dropout pulse of one sampled cycle
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); supply_ok = 1'b1;
        step(FLAG_LAT - 1);
        check("R8 dropout flag", rd, 8'h80);
        step(4);
        check("R8 dropout sticky", rd, 8'h80);
        do_write(1'b0, 8'h80);
        check("R7 dropout rearm", rd, 8'h00);

        // R10 clear port leaves flags alone
        srst_sense = 1'b1; supply_ok = 1'b0;
        @(negedge clk); srst_sense = 1'b0; supply_ok = 1'b1;
        step(FLAG_LAT);
        do_write(1'b0, 8'h18);
        check("R5 flags and controls packed", rd, 8'hD8);
        do_write(1'b1, 8'hFF);
        check("R10 clear keeps flags", rd, 8'hC0);
        do_write(1'b0, 8'hC0);
        check("R7 both rearmed", rd, 8'h00);

        // R4 reset in mid-run
        do_write(1'b0, CTRL_BITS);
        srst_sense = 1'b1;
        step(FLAG_LAT);
        srst_sense = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R4 mid-run reset", rd, 8'h00);
        rst_n = 1'b1;
        step(4);
        check("R4 stays clear", rd, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule